// File: doc/BRIEF.md
# Fuse byte read controller

This block serves reads of a one-time-programmable byte array through a single 32-bit control register. Software writes the register with an address and with the completion flag at zero. That write starts an access to the addressed fuse byte. The controller marks itself busy and clears the flag. When the array returns the byte, the controller puts it in the low byte of the same register and sets the flag again. Software polls the flag, then reads the byte out of the register it wrote.

A bank-select input picks one of several fuse banks. Its value is captured at the moment an access starts, so changes on that input during an access do not affect the byte returned. The array in this block is a behavioural model whose contents are computed from bank and address. It answers after a fixed latency, set as a parameter in clock cycles. The controller accepts one access at a time and always completes it, so a polling loop always ends.

Top module: `fuse_rd_ctrl`

## Requirements
- R1: After reset, the register reads 0x8000_0000. That is: flag set, address field 0, data field 0. The captured bank is 0.
- R2: Register layout. Bit 31 is the completion flag. Bits 17:8 hold the 10-bit fuse address. Bits 7:0 hold the read data. Every other bit reads as zero.
- R3: A write with bit 31 at zero, made while the controller is idle, starts an access. From the next cycle, the address field shows bits 17:8 of the written value and the flag reads 0. The low byte of the written value is discarded.
- R4: Count the clock edge that accepts the start as edge 0. The flag reads 0 after edges 0 to LATENCY-1 and reads 1 after edge LATENCY. From that edge on, the data field holds the fuse byte.
- R5: Every access completes. The controller never stays busy longer than LATENCY cycles.
- R6: While an access is in progress, any write is ignored. The address, the captured bank and the result stay those of the access in progress, and no second access follows.
- R7: A write with bit 31 at one starts nothing and leaves the register unchanged.
- R8: The data field keeps its last value until the next access completes. This includes the cycles while an access is in progress.
- R9: The bank-select value is captured on the start edge. Changes on that input during the access do not change the byte returned.
- R10: The fuse byte for address a and bank b is ((3*a + 64*(a div 256)) xor (92*b)) mod 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Control register write strobe |
| reg_wr_data | input | 32 | Control register write value |
| bank_sel | input | BANK_W | Fuse bank select, captured when an access starts |
| reg_rd_data | output | 32 | Control register read value: flag, address and data |

## Verification
Assertions check the following on every cycle:
- an accepted start clears the flag on the next cycle;
- a returned byte sets the flag;
- the address is held while the controller is busy;
- the data field moves only when a byte returns;
- the busy time stays within LATENCY;
- at most one access is in flight inside the array.

The bench sweeps every address in every bank and checks each of the following cycle by cycle:
- the exact edge on which the flag rises;
- the computed byte value;
- that the previous byte is held during the access.

Only these scenarios can show several further behaviours:
- writes during a busy period are dropped entirely;
- a bank change during an access has no effect;
- a write with the flag set changes nothing.

// File: rtl/fuse_rd_pkg.sv
package fuse_rd_pkg;

   localparam int REG_W    = 32;
   localparam int FLAG_BIT = 31;
   localparam int ADDR_LSB = 8;
   localparam int DATA_W   = 8;

   // Behavioural fuse contents for bank b, address a.
   function automatic logic [DATA_W-1:0] fuse_pattern(input int bank, input int addr);
      int mix;
      mix = ((addr * 3) + ((addr >> 8) * 64)) ^ (bank * 92);
      return DATA_W'(mix);
   endfunction

endpackage

// File: rtl/fuse_array_model.sv
module fuse_array_model
   import fuse_rd_pkg::*;
#(
   parameter int ADDR_W  = 10,
   parameter int BANK_W  = 2,
   parameter int LATENCY = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic [BANK_W-1:0] bank_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              vld_o,
   output logic [DATA_W-1:0] data_o
);

   initial begin
      if (LATENCY < 1) $error("fuse_array_model: LATENCY must be at least 1");
      if (ADDR_W < 1 || ADDR_W > 16) $error("fuse_array_model: ADDR_W out of range");
   end

   logic [LATENCY-1:0] vld_q;
   logic [DATA_W-1:0]  dat_q [LATENCY];
   logic [DATA_W-1:0]  fetch;

   assign fetch = fuse_pattern(int'(bank_i), int'(addr_i));

   generate
      if (LATENCY == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               vld_q[0] <= 1'b0;
               dat_q[0] <= '0;
            end else begin
               vld_q[0] <= req_i;
               if (req_i) dat_q[0] <= fetch;
            end
         end
      end else begin : g_pipe
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               vld_q <= '0;
               for (int k = 0; k < LATENCY; k++) dat_q[k] <= '0;
            end else begin
               vld_q <= {vld_q[LATENCY-2:0], req_i};
               if (req_i) dat_q[0] <= fetch;
               for (int k = 1; k < LATENCY; k++) dat_q[k] <= dat_q[k-1];
            end
         end
      end
   endgenerate

   assign vld_o  = vld_q[LATENCY-1];
   assign data_o = dat_q[LATENCY-1];

   // R6: the controller never lets two accesses overlap inside the array
   p_one_in_flight_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(vld_q) <= 1);

endmodule

// File: rtl/fuse_rd_seq.sv
module fuse_rd_seq
   import fuse_rd_pkg::*;
#(
   parameter int ADDR_W  = 10,
   parameter int BANK_W  = 2,
   parameter int LATENCY = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic              wr_flag_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [BANK_W-1:0] bank_i,
   input  logic              resp_vld_i,
   input  logic [DATA_W-1:0] resp_data_i,
   output logic              start_o,
   output logic [ADDR_W-1:0] req_addr_o,
   output logic [BANK_W-1:0] req_bank_o,
   output logic [REG_W-1:0]  rd_data_o
);

   localparam int CNT_W = $clog2(LATENCY + 2);

   initial begin
      if (ADDR_LSB + ADDR_W > FLAG_BIT)
         $error("fuse_rd_seq: address field overlaps the flag bit");
      if (DATA_W > ADDR_LSB)
         $error("fuse_rd_seq: data field overlaps the address field");
   end

   logic              busy_q;
   logic              flag_q;
   logic [ADDR_W-1:0] addr_q;
   logic [BANK_W-1:0] bank_q;
   logic [DATA_W-1:0] data_q;

   assign start_o    = wr_en_i && !wr_flag_i && !busy_q;
   assign req_addr_o = wr_addr_i;
   assign req_bank_o = bank_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         flag_q <= 1'b1;
         addr_q <= '0;
         bank_q <= '0;
         data_q <= '0;
      end else if (start_o) begin
         busy_q <= 1'b1;
         flag_q <= 1'b0;
         addr_q <= wr_addr_i;
         bank_q <= bank_i;
      end else if (busy_q && resp_vld_i) begin
         busy_q <= 1'b0;
         flag_q <= 1'b1;
         data_q <= resp_data_i;
      end
   end

   always_comb begin
      rd_data_o                        = '0;
      rd_data_o[FLAG_BIT]              = flag_q;
      rd_data_o[ADDR_LSB +: ADDR_W]    = addr_q;
      rd_data_o[DATA_W-1:0]            = data_q;
   end

   // cycle counter for the completion bound
   logic [CNT_W-1:0] wait_cnt;
   always_ff @(posedge clk) begin
      if (!rst_n)         wait_cnt <= '0;
      else if (start_o)   wait_cnt <= '0;
      else if (busy_q)    wait_cnt <= wait_cnt + 1'b1;
   end

   p_start_clears_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |=> !rd_data_o[FLAG_BIT]);

   p_done_sets_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && resp_vld_i) |=> rd_data_o[FLAG_BIT]);

   p_bounded_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (wait_cnt < CNT_W'(LATENCY)));

   p_busy_holds_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |=> ($stable(addr_q) && $stable(bank_q)));

   p_data_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !resp_vld_i |=> $stable(data_q));

   p_resp_only_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      resp_vld_i |-> busy_q);

   logic unused_bank;
   assign unused_bank = ^bank_q;

endmodule

// File: rtl/fuse_rd_ctrl.sv
module fuse_rd_ctrl
   import fuse_rd_pkg::*;
#(
   parameter int ADDR_W  = 10,
   parameter int BANK_W  = 2,
   parameter int LATENCY = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [31:0]       reg_wr_data,
   input  logic [BANK_W-1:0] bank_sel,
   output logic [31:0]       reg_rd_data
);

   initial begin
      if (REG_W != 32) $error("fuse_rd_ctrl: register must be 32 bits");
      if (BANK_W < 1 || BANK_W > 4) $error("fuse_rd_ctrl: BANK_W out of range");
   end

   logic              start;
   logic [ADDR_W-1:0] req_addr;
   logic [BANK_W-1:0] req_bank;
   logic              resp_vld;
   logic [DATA_W-1:0] resp_data;

   fuse_rd_seq #(
      .ADDR_W (ADDR_W),
      .BANK_W (BANK_W),
      .LATENCY(LATENCY)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en_i    (reg_wr_en),
      .wr_flag_i  (reg_wr_data[FLAG_BIT]),
      .wr_addr_i  (reg_wr_data[ADDR_LSB +: ADDR_W]),
      .bank_i     (bank_sel),
      .resp_vld_i (resp_vld),
      .resp_data_i(resp_data),
      .start_o    (start),
      .req_addr_o (req_addr),
      .req_bank_o (req_bank),
      .rd_data_o  (reg_rd_data)
   );

   fuse_array_model #(
      .ADDR_W (ADDR_W),
      .BANK_W (BANK_W),
      .LATENCY(LATENCY)
   ) u_array (
      .clk   (clk),
      .rst_n (rst_n),
      .req_i (start),
      .bank_i(req_bank),
      .addr_i(req_addr),
      .vld_o (resp_vld),
      .data_o(resp_data)
   );

   logic unused_wr;
   assign unused_wr = ^{reg_wr_data[FLAG_BIT-1:ADDR_LSB+ADDR_W], reg_wr_data[ADDR_LSB-1:0]};

endmodule

// File: tb/sim_fuse_rd_ctrl.sv
`timescale 1ns/1ps
module sim_fuse_rd_ctrl;

   localparam int LAT = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [31:0] reg_wr_data = '0;
   logic [1:0]  bank_sel = '0;
   logic [31:0] reg_rd_data;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   fuse_rd_ctrl #(.ADDR_W(10), .BANK_W(2), .LATENCY(LAT)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en),
      .reg_wr_data(reg_wr_data), .bank_sel(bank_sel), .reg_rd_data(reg_rd_data)
   );

   function automatic logic [7:0] exp_byte(int a, int b);
      return 8'((((3 * a) + (64 * (a / 256))) ^ (92 * b)) % 256);
   endfunction

   function automatic logic [31:0] reg_val(bit f, int a, logic [7:0] d);
      return {f, 13'd0, 10'(a), d};
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   // one access; returns the byte and checks every cycle
   task automatic do_read(int a, int b, inout logic [7:0] prev);
      @(negedge clk);
      reg_wr_en   = 1'b1;
      reg_wr_data = {1'b0, 13'h1abc, 10'(a), 8'hc3};
      bank_sel    = 2'(b);
      @(posedge clk);
      @(negedge clk);
      reg_wr_en = 1'b0;
      bank_sel  = 2'(b ^ 3);   // R9: changes after capture must not matter
      chk("R3 start", reg_rd_data, reg_val(1'b0, a, prev));
      for (int k = 1; k <= LAT; k++) begin
         @(posedge clk);
         @(negedge clk);
         if (k < LAT) chk("R8 hold while busy", reg_rd_data, reg_val(1'b0, a, prev));
         else         chk("R4 R10 R2 R9 result", reg_rd_data, reg_val(1'b1, a, exp_byte(a, b)));
      end
      prev = exp_byte(a, b);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_chk++;
         $display("FAIL R5 watchdog act=hung exp=complete");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [7:0] prev;
      prev = 8'h00;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      chk("R1 reset", reg_rd_data, 32'h8000_0000);

      // R7: write with flag set changes nothing
      @(negedge clk);
      reg_wr_en = 1'b1;
      reg_wr_data = 32'h8003_55aa;
      @(posedge clk);
      @(negedge clk);
      reg_wr_en = 1'b0;
      chk("R7 flag-set write", reg_rd_data, 32'h8000_0000);
      repeat (LAT + 1) @(posedge clk);
      @(negedge clk);
      chk("R7 no access", reg_rd_data, 32'h8000_0000);

      // sweep all banks and addresses
      for (int b = 0; b < 4; b++)
         for (int a = 0; a < 1024; a++)
            do_read(a, b, prev);

      // R6: write during busy is dropped
      @(negedge clk);
      reg_wr_en = 1'b1;
      reg_wr_data = {1'b0, 13'd0, 10'd777, 8'h00};
      bank_sel = 2'd2;
      @(posedge clk);
      @(negedge clk);
      reg_wr_data = {1'b0, 13'd0, 10'd5, 8'h00};
      bank_sel = 2'd1;
      @(posedge clk);
      @(negedge clk);
      reg_wr_en = 1'b0;
      chk("R6 addr held", reg_rd_data, reg_val(1'b0, 777, prev));
      repeat (LAT - 1) @(posedge clk);
      @(negedge clk);
      chk("R6 R9 first result", reg_rd_data, reg_val(1'b1, 777, exp_byte(777, 2)));
      repeat (LAT + 2) @(posedge clk);
      @(negedge clk);
      chk("R6 no second access", reg_rd_data, reg_val(1'b1, 777, exp_byte(777, 2)));

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule